// File: doc/BRIEF.md
# Armed Flash Programming Command Decoder

This block sits at the front of a parallel programming port. An external host uses that port to erase, program and verify the on-chip flash of a small microcontroller while the CPU is held in reset. The block recognises when the host takes over the pins. It gathers a 16-bit address, an 8-bit data byte and a 4-bit command from the reassigned port pins, and it serves the read-type commands directly from signature constants, the lock state or the flash read port.

Write-type commands (erases, byte program, lock programming) are guarded twice:

- **Arming.** Nothing is issued until the host has read all three signature bytes in the current host session.
- **Lock permissions.** The current lock-bit protection level decides whether the command may proceed.

A write command that passes both guards produces a single-cycle start request toward a separate write engine, carrying an operation code, the address and the data. The falling edge of the program strobe triggers the request, after the strobe has passed through a synchroniser. The flash array, the write timing and supply sensing live elsewhere. Power loss and mode changes arrive as single-cycle pulses.

Top module: `flash_host_decoder`

## Requirements
- R1: `host_mode` goes high one clock after `pin_rst` is 1 and `pin_store_en_n` is 0 are both seen at a clock edge. It goes low one clock after either condition is gone.
- R2: The command code is {`p3_ctl_in[1]`, `p3_ctl_in[0]`, `p2_in[7]`, `p2_in[6]`}. With command 0h in host mode, `rd_valid` is 1 and `rd_data` is combinationally set by the address as follows:
  - 0030h gives D5h.
  - 0031h gives the size code (04h, 08h or 10h for the 16K, 32K or 64K array; 10h by default).
  - 0032h gives FFh for a 12 V supply or 55h for a 5 V supply (FFh by default).
  - Any other address gives 00h.
- R3: `armed` is 0 until each of the addresses 0030h, 0031h and 0032h has been presented with command 0h at a clock edge in host mode. It goes high right after the clock edge that completes the set. No write command produces a start while `armed` is 0.
- R4: A `power_lost` or `mode_change` pulse clears `armed` at the next edge. Leaving host mode clears it one edge after `host_mode` falls. Each case requires all three signature reads again.
- R5: An accepted write produces `wr_start` high for exactly one cycle, starting three clock edges after `strobe_n` falls. The address is {`p3_addr_in[1]`, `p3_addr_in[0]`, `p2_in[5:0]`, `p1_in`} and the data is `p0_in`. The `wr_op` codes are:
  - chip erase (1h) = 1
  - block-1 erase (2h) = 2
  - block-2 erase (4h) = 3
  - program byte (Eh) = 4
  - lock bit 1 (Fh) = 5
  - lock bit 2 (3h) = 6
  - lock bit 3 (5h) = 7
  
  Lock-bit programming is accepted at every lock level.
- R6: Chip erase is accepted whatever the value of `lock_bits`.
- R7: Block-1 erase, block-2 erase and byte program are refused (no start) when `lock_bits[1]` (lock 2) or `lock_bits[2]` (lock 3) is set.
- R8: Block-2 erase is accepted only when the array size selection is the 64K one (the default), subject to R7.
- R9: With command Ch, `rd_valid` is 1 and `rd_data` equals `flash_rd_data` when `lock_bits` is 000. Otherwise `rd_valid` is 0 and `rd_data` is 00h. `flash_rd_addr` always carries the assembled address.
- R10: With command 9h in host mode, `rd_valid` is 1 and `rd_data` is {4'b0000, `lock_bits`, 1'b0} at every lock level.
- R11: An armed write command whose strobe edge arrives while `eng_busy` is 1 produces no start and sets the sticky `rejected` output. `rejected` is cleared when host mode is left.
- R12: The read codes (0h, 9h, Ch) and the unused codes produce no start, even when armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_rst | input | 1 | Level of the device reset pin |
| pin_store_en_n | input | 1 | Program-store-enable pin, low selects host mode |
| strobe_n | input | 1 | Program strobe, falling edge triggers writes |
| p3_ctl_in | input | 2 | Command bits 3..2 (P3.7, P3.6) |
| p3_addr_in | input | 2 | Address bits 15..14 (P3.3, P3.2) |
| p2_in | input | 8 | Bits 7..6 command bits 1..0, bits 5..0 address 13..8 |
| p1_in | input | 8 | Address bits 7..0 |
| p0_in | input | 8 | Write data byte |
| lock_bits | input | 3 | Current lock state, bit0 lock 1 .. bit2 lock 3 |
| flash_rd_data | input | 8 | Byte read from the array at `flash_rd_addr` |
| eng_busy | input | 1 | Write engine busy |
| power_lost | input | 1 | Power-loss pulse |
| mode_change | input | 1 | Mode-change pulse |
| host_mode | output | 1 | Host programming mode active |
| armed | output | 1 | All signature bytes read in this session |
| rd_valid | output | 1 | `rd_data` is driven with valid read data |
| rd_data | output | 8 | Read data toward port 0 |
| flash_rd_addr | output | 16 | Assembled address for array reads |
| wr_start | output | 1 | One-cycle start request to the write engine |
| wr_op | output | 3 | Operation code held with the start |
| wr_addr | output | 16 | Address held with the start |
| wr_data | output | 8 | Data held with the start |
| rejected | output | 1 | Sticky: a write arrived while the engine was busy |

## Verification
The bench sweeps all sixteen command codes against all eight lock states once the block is armed. A block that inverts the lock-2/lock-3 guard, lets a locked program through, or blocks chip erase under lock would issue or withhold a start on the wrong vectors.

Arming is probed with partial signature sequences and with each of the three disarm events. A tracker that arms on the first signature byte, or that keeps its state across a power-loss pulse, would let a write through that must be ignored.

The start pulse is sampled on the exact cycle the synchroniser implies and again one cycle later. This catches an extra flop, a missing edge register, or a level-sensitive start that repeats.

The busy case checks both that no start is issued and that the sticky flag is set and then cleared on exiting host mode.

// File: rtl/fhd_pkg.sv
package fhd_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CMD_W  = 4;
    localparam int LOCK_W = 3;
    localparam int SIG_N  = 3;
    localparam logic [ADDR_W-1:0] SIG_BASE = 16'h0030;
    localparam logic [DATA_W-1:0] MAKER_CODE = 8'hD5;

    typedef enum logic [CMD_W-1:0] {
        CMD_SIG         = 4'h0,
        CMD_CHIP_ERASE  = 4'h1,
        CMD_ERASE_B1    = 4'h2,
        CMD_LOCK2       = 4'h3,
        CMD_ERASE_B2    = 4'h4,
        CMD_LOCK3       = 4'h5,
        CMD_VERIFY_LOCK = 4'h9,
        CMD_VERIFY_CODE = 4'hC,
        CMD_PROGRAM     = 4'hE,
        CMD_LOCK1       = 4'hF
    } host_cmd_e;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_CHIP_ERASE = 3'd1,
        OP_ERASE_B1   = 3'd2,
        OP_ERASE_B2   = 3'd3,
        OP_PROGRAM    = 3'd4,
        OP_LOCK1      = 3'd5,
        OP_LOCK2      = 3'd6,
        OP_LOCK3      = 3'd7
    } wr_op_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    function automatic logic [DATA_W-1:0] size_code(int unsigned sel);
        if (sel == 0)      return 8'h04;
        else if (sel == 1) return 8'h08;
        else               return 8'h10;
    endfunction

    function automatic logic [DATA_W-1:0] sig_byte(logic [ADDR_W-1:0] addr,
                                                   int unsigned sel, bit hi_supply);
        if (addr == SIG_BASE)              return MAKER_CODE;
        else if (addr == SIG_BASE + 16'd1) return size_code(sel);
        else if (addr == SIG_BASE + 16'd2) return hi_supply ? 8'hFF : 8'h55;
        else                               return 8'h00;
    endfunction

    function automatic logic is_write(logic [CMD_W-1:0] cmd);
        case (cmd)
            CMD_CHIP_ERASE, CMD_ERASE_B1, CMD_ERASE_B2, CMD_PROGRAM,
            CMD_LOCK1, CMD_LOCK2, CMD_LOCK3: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

    // Permitted operation for a command at a lock level; OP_NONE when refused.
    function automatic wr_op_e classify(logic [CMD_W-1:0] cmd,
                                        logic [LOCK_W-1:0] lock, bit block2_ok);
        logic guarded;
        guarded = lock[1] | lock[2];
        case (cmd)
            CMD_CHIP_ERASE: return OP_CHIP_ERASE;
            CMD_ERASE_B1:   return guarded ? OP_NONE : OP_ERASE_B1;
            CMD_ERASE_B2:   return (guarded || !block2_ok) ? OP_NONE : OP_ERASE_B2;
            CMD_PROGRAM:    return guarded ? OP_NONE : OP_PROGRAM;
            CMD_LOCK1:      return OP_LOCK1;
            CMD_LOCK2:      return OP_LOCK2;
            CMD_LOCK3:      return OP_LOCK3;
            default:        return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/fhd_pin_map.sv
module fhd_pin_map
    import fhd_pkg::*;
(
    input  logic [1:0]        p3_ctl,
    input  logic [1:0]        p3_addr,
    input  logic [7:0]        p2,
    input  logic [7:0]        p1,
    input  logic [DATA_W-1:0] p0,
    output host_req_t         req
);
    always_comb begin
        req.cmd  = {p3_ctl, p2[7:6]};
        req.addr = {p3_addr, p2[5:0], p1};
        req.data = p0;
    end
endmodule

// File: rtl/fhd_strobe_sync.sv
module fhd_strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    // SYNC_STAGES synchroniser flops followed by one edge register.
    localparam int CHAIN_W = SYNC_STAGES + 1;
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[CHAIN_W-2:0], strobe_n};
    end

    assign fall = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
endmodule

// File: rtl/fhd_arm_track.sv
module fhd_arm_track
    import fhd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_mode,
    input  logic      power_lost,
    input  logic      mode_change,
    input  host_req_t req,
    output logic      armed
);
    logic [SIG_N-1:0] seen;
    logic             drop;

    assign drop = rst | ~host_mode | power_lost | mode_change;

    for (genvar i = 0; i < SIG_N; i++) begin : g_sig
        always_ff @(posedge clk) begin
            if (drop)
                seen[i] <= 1'b0;
            else if (req.cmd == CMD_SIG && req.addr == SIG_BASE + ADDR_W'(i))
                seen[i] <= 1'b1;
        end
    end

    assign armed = &seen;
endmodule

// File: rtl/fhd_read_mux.sv
module fhd_read_mux
    import fhd_pkg::*;
#(
    parameter int unsigned SIZE_SEL    = 2,
    parameter bit          HIGH_SUPPLY = 1'b1
) (
    input  logic              host_mode,
    input  host_req_t         req,
    input  logic [LOCK_W-1:0] lock,
    input  logic [DATA_W-1:0] flash_rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        if (host_mode) begin
            case (req.cmd)
                CMD_SIG: begin
                    rd_valid = 1'b1;
                    rd_data  = sig_byte(req.addr, SIZE_SEL, HIGH_SUPPLY);
                end
                CMD_VERIFY_LOCK: begin
                    rd_valid = 1'b1;
                    rd_data  = {4'b0000, lock, 1'b0};
                end
                CMD_VERIFY_CODE: begin
                    if (lock == '0) begin
                        rd_valid = 1'b1;
                        rd_data  = flash_rd_data;
                    end
                end
                default: begin
                    rd_valid = 1'b0;
                    rd_data  = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fhd_issue.sv
module fhd_issue
    import fhd_pkg::*;
#(
    parameter bit BLOCK2_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              host_mode,
    input  logic              armed,
    input  logic              busy,
    input  logic [LOCK_W-1:0] lock,
    input  host_req_t         req,
    output logic              start,
    output wr_op_e            op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              rejected
);
    wr_op_e permitted;
    logic   attempt;
    logic   accept;

    always_comb begin
        permitted = classify(req.cmd, lock, BLOCK2_OK);
        attempt   = fall & host_mode & armed & is_write(req.cmd);
        accept    = attempt & ~busy & (permitted != OP_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start    <= 1'b0;
            op       <= OP_NONE;
            addr     <= '0;
            data     <= '0;
            rejected <= 1'b0;
        end else begin
            start <= accept;
            if (accept) begin
                op   <= permitted;
                addr <= req.addr;
                data <= req.data;
            end
            if (!host_mode)          rejected <= 1'b0;
            else if (attempt & busy) rejected <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_host_decoder.sv
module flash_host_decoder
    import fhd_pkg::*;
#(
    parameter int unsigned SIZE_SEL    = 2,
    parameter bit          HIGH_SUPPLY = 1'b1,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst,
    input  logic              pin_store_en_n,
    input  logic              strobe_n,
    input  logic [1:0]        p3_ctl_in,
    input  logic [1:0]        p3_addr_in,
    input  logic [7:0]        p2_in,
    input  logic [7:0]        p1_in,
    input  logic [7:0]        p0_in,
    input  logic [2:0]        lock_bits,
    input  logic [7:0]        flash_rd_data,
    input  logic              eng_busy,
    input  logic              power_lost,
    input  logic              mode_change,
    output logic              host_mode,
    output logic              armed,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic [15:0]       flash_rd_addr,
    output logic              wr_start,
    output logic [2:0]        wr_op,
    output logic [15:0]       wr_addr,
    output logic [7:0]        wr_data,
    output logic              rejected
);
    localparam bit BLOCK2_OK = (SIZE_SEL == 2);

    host_req_t req;
    logic      fall;
    wr_op_e    op_q;

    always_ff @(posedge clk) begin
        if (rst) host_mode <= 1'b0;
        else     host_mode <= pin_rst & ~pin_store_en_n;
    end

    fhd_pin_map i_map (
        .p3_ctl  (p3_ctl_in),
        .p3_addr (p3_addr_in),
        .p2      (p2_in),
        .p1      (p1_in),
        .p0      (p0_in),
        .req     (req)
    );

    fhd_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (strobe_n),
        .fall     (fall)
    );

    fhd_arm_track i_arm (
        .clk         (clk),
        .rst         (rst),
        .host_mode   (host_mode),
        .power_lost  (power_lost),
        .mode_change (mode_change),
        .req         (req),
        .armed       (armed)
    );

    fhd_read_mux #(.SIZE_SEL(SIZE_SEL), .HIGH_SUPPLY(HIGH_SUPPLY)) i_rd (
        .host_mode     (host_mode),
        .req           (req),
        .lock          (lock_bits),
        .flash_rd_data (flash_rd_data),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data)
    );

    fhd_issue #(.BLOCK2_OK(BLOCK2_OK)) i_issue (
        .clk       (clk),
        .rst       (rst),
        .fall      (fall),
        .host_mode (host_mode),
        .armed     (armed),
        .busy      (eng_busy),
        .lock      (lock_bits),
        .req       (req),
        .start     (wr_start),
        .op        (op_q),
        .addr      (wr_addr),
        .data      (wr_data),
        .rejected  (rejected)
    );

    assign wr_op         = op_q;
    assign flash_rd_addr = req.addr;
endmodule

// File: rtl/fhd_checker.sv
module fhd_checker
    import fhd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_mode,
    input logic       armed,
    input logic       wr_start,
    input logic [2:0] wr_op,
    input logic [2:0] lock_bits,
    input logic       rd_valid,
    input logic [1:0] p3_ctl_in,
    input logic [7:0] p2_in,
    input logic       eng_busy,
    input logic       rejected
);
    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !wr_start);

    // R5
    start_op_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> wr_op != 3'(OP_NONE));

    // R3
    start_armed_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> $past(armed));

    // R7
    locked_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_start && (wr_op == 3'(OP_ERASE_B1) || wr_op == 3'(OP_ERASE_B2)
                      || wr_op == 3'(OP_PROGRAM)))
        |-> $past(lock_bits[2:1]) == 2'b00);

    // R4
    exit_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        !host_mode |=> !armed);

    // R9
    verify_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && {p3_ctl_in, p2_in[7:6]} == 4'hC) |-> lock_bits == 3'b000);

    // R11
    busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        wr_start |-> !$past(eng_busy));

    // R11
    reject_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rejected) |-> $past(eng_busy));
endmodule

bind flash_host_decoder fhd_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .host_mode (host_mode),
    .armed     (armed),
    .wr_start  (wr_start),
    .wr_op     (wr_op),
    .lock_bits (lock_bits),
    .rd_valid  (rd_valid),
    .p3_ctl_in (p3_ctl_in),
    .p2_in     (p2_in),
    .eng_busy  (eng_busy),
    .rejected  (rejected)
);

// File: tb/test_flash_host_decoder.sv
module test_flash_host_decoder;

    logic        clk = 1'b0;
    logic        rst, pin_rst, pin_store_en_n, strobe_n;
    logic [1:0]  p3_ctl_in, p3_addr_in;
    logic [7:0]  p2_in, p1_in, p0_in, flash_rd_data, rd_data, wr_data;
    logic [2:0]  lock_bits, wr_op;
    logic        eng_busy, power_lost, mode_change;
    logic        host_mode, armed, rd_valid, wr_start, rejected;
    logic [15:0] flash_rd_addr, wr_addr;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    flash_host_decoder i_flash_host_decoder (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    endtask

    task automatic set_pins(input logic [3:0] cmd, input logic [15:0] addr, input logic [7:0] data);
        p3_ctl_in  = cmd[3:2];
        p2_in      = {cmd[1:0], addr[13:8]};
        p3_addr_in = addr[15:14];
        p1_in      = addr[7:0];
        p0_in      = data;
    endtask

    function automatic logic [2:0] exp_op(input logic [3:0] cmd, input logic [2:0] lk);
        logic free;
        free = (lk[2:1] == 2'b00);
        case (cmd)
            4'h1:    return 3'd1;
            4'h2:    return free ? 3'd2 : 3'd0;
            4'h4:    return free ? 3'd3 : 3'd0;
            4'hE:    return free ? 3'd4 : 3'd0;
            4'hF:    return 3'd5;
            4'h3:    return 3'd6;
            4'h5:    return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] cmd);
        case (cmd)
            4'h1:             return "R6 chip erase";
            4'h2, 4'hE:       return "R7 locked write";
            4'h4:             return "R8 block2 erase";
            4'h3, 4'h5, 4'hF: return "R5 lock program";
            default:          return "R12 non-write code";
        endcase
    endfunction

    task automatic run_write(input logic [3:0] cmd, input logic [15:0] addr,
                             input logic [7:0] data, input logic [2:0] exp, input string tag);
        @(negedge clk);
        set_pins(cmd, addr, data);
        strobe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tag, wr_start, exp != 3'd0);
        if (exp != 3'd0) begin
            check(tag, wr_op, exp);
            check(tag, wr_addr, addr);
            check(tag, wr_data, data);
        end
        strobe_n = 1'b1;
        @(negedge clk);
        check(tag, wr_start, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_sig(input logic [15:0] addr, input logic [7:0] exp);
        @(negedge clk);
        set_pins(4'h0, addr, 8'h00);
        #1;
        check("R2 signature valid", rd_valid, 1);
        check("R2 signature byte", rd_data, exp);
        @(negedge clk);
    endtask

    task automatic arm_all();
        read_sig(16'h0030, 8'hD5);
        read_sig(16'h0031, 8'h10);
        read_sig(16'h0032, 8'hFF);
        check("R3 armed after three reads", armed, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; pin_rst = 1'b0; pin_store_en_n = 1'b1; strobe_n = 1'b1;
        set_pins(4'h0, 16'h0000, 8'h00);
        lock_bits = 3'b000; flash_rd_data = 8'h3C;
        eng_busy = 1'b0; power_lost = 1'b0; mode_change = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset host_mode", host_mode, 0);
        check("R3 reset armed", armed, 0);
        check("R5 reset start", wr_start, 0);
        check("R2 reset rd_valid", rd_valid, 0);
        check("R11 reset rejected", rejected, 0);

        // R1: entry
        pin_rst = 1'b1; pin_store_en_n = 1'b0;
        @(negedge clk);
        check("R1 host entry", host_mode, 1);

        // R3: writes ignored before arming
        run_write(4'hE, 16'h0100, 8'h5A, 3'd0, "R3 unarmed program");
        run_write(4'h1, 16'h0000, 8'h00, 3'd0, "R3 unarmed chip erase");
        read_sig(16'h0030, 8'hD5);
        read_sig(16'h0031, 8'h10);
        check("R3 partial not armed", armed, 0);
        run_write(4'h1, 16'h0000, 8'h00, 3'd0, "R3 partial arm chip erase");
        read_sig(16'h0032, 8'hFF);
        check("R3 armed", armed, 1);
        read_sig(16'h0033, 8'h00);

        // R5..R8, R12: all codes against all lock states
        for (int lk = 0; lk < 8; lk++) begin
            for (int c = 0; c < 16; c++) begin
                logic [15:0] a;
                logic [7:0]  d;
                a = {4'(c), 4'h5, 1'b0, 3'(lk), 4'hA};
                d = 8'hA0 ^ 8'(c) ^ 8'(lk << 4);
                lock_bits = 3'(lk);
                run_write(4'(c), a, d, exp_op(4'(c), 3'(lk)), tag_of(4'(c)));
            end
        end

        // R9, R10: verify paths over lock states
        for (int lk = 0; lk < 8; lk++) begin
            @(negedge clk);
            lock_bits = 3'(lk);
            flash_rd_data = 8'h3C ^ 8'(lk);
            set_pins(4'hC, 16'h4321, 8'h00);
            #1;
            check("R9 code verify valid", rd_valid, lk == 0);
            check("R9 code verify data", rd_data, (lk == 0) ? 8'h3C : 8'h00);
            check("R9 read address", flash_rd_addr, 16'h4321);
            set_pins(4'h9, 16'h0000, 8'h00);
            #1;
            check("R10 lock verify valid", rd_valid, 1);
            check("R10 lock verify data", rd_data, {4'b0000, 3'(lk), 1'b0});
        end
        lock_bits = 3'b000;

        // R11: busy rejection
        eng_busy = 1'b1;
        run_write(4'hE, 16'h0200, 8'h11, 3'd0, "R11 busy program");
        check("R11 rejected set", rejected, 1);
        eng_busy = 1'b0;
        run_write(4'hE, 16'h0200, 8'h11, 3'd4, "R11 program after busy");
        check("R11 rejected sticky", rejected, 1);

        // R4: disarm events
        @(negedge clk); power_lost = 1'b1;
        @(negedge clk); power_lost = 1'b0;
        check("R4 power loss disarms", armed, 0);
        run_write(4'h1, 16'h0000, 8'h00, 3'd0, "R4 write after power loss");
        arm_all();
        @(negedge clk); mode_change = 1'b1;
        @(negedge clk); mode_change = 1'b0;
        check("R4 mode change disarms", armed, 0);
        run_write(4'hE, 16'h0300, 8'h22, 3'd0, "R4 write after mode change");
        arm_all();
        @(negedge clk); pin_store_en_n = 1'b1;
        @(negedge clk);
        check("R1 host exit", host_mode, 0);
        @(negedge clk);
        check("R4 exit disarms", armed, 0);
        check("R11 rejected cleared on exit", rejected, 0);
        pin_rst = 1'b0; pin_store_en_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 no entry without reset pin", host_mode, 0);

        finish_run();
    end
endmodule